// File: doc/BRIEF.md
# Register-Controlled Pad Function Multiplexer

This block sits between a set of on-chip peripheral signals and the chip's pads. Each peripheral signal has three wires on the core side: output data, output enable and input data. Pads come in two kinds. Dedicated pads are hard-wired to one peripheral signal. Muxed pads each hold a small select register that picks one of the functions available on that pad. Both data and direction (output enable) are steered together, so bidirectional signals such as the two-wire serial clock and data lines work through the same path.

Pads may offer different numbers of functions, so each select register is only as wide as its own pad needs. On the way back into the core, one peripheral input can be reachable from several pads. The lowest-numbered pad that currently selects it wins. An input that no pad selects is held at a per-signal idle level, for example high for a serial receive line or a chip select. Software reads and writes the select registers through an AXI4-Lite slave port. All pad outputs and peripheral inputs are registered, so a change appears one clock after its cause.

Top module: `padmux_ctrl`

## Requirements
- R1: After reset every select register reads 0, which places each muxed pad on its first function.
- R2: Muxed pad p offers F(p) = 2 + (p mod (MAX_FUNC-1)) functions. Its select register stores max(1, ceil(log2 F(p))) bits. Higher written bits are dropped and read back as 0.
- R3: Function f of muxed pad p is peripheral signal (p + 3f) mod N_MUX_SIG. With a valid select, pad_out and pad_oe copy that signal's periph_out and periph_oe, one clock later.
- R4: A select value of F(p) or more drives pad_out and pad_oe of that pad to 0.
- R5: Dedicated pad N_MUX_PADS+d always carries peripheral signal N_MUX_SIG+d in both directions, with one clock of delay.
- R6: periph_in of a muxed signal follows pad_in of the lowest-numbered pad whose valid select names it, one clock later.
- R7: A muxed signal that no pad selects drives periph_in to its IN_DEFAULT bit.
- R8: The register of muxed pad p sits at byte address p*REG_STRIDE. Its value occupies byte lane (address mod 4) of the 32-bit data bus. A write changes it only when that lane's strobe bit is set.
- R9: A misaligned address, or one naming no muxed pad, gets response 2'b10 (SLVERR). A write to it changes no register, and a read of it returns 0. Mapped accesses get 2'b00.
- R10: Every accepted write produces one write response. A response of either kind is held stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| periph_out | input | N_SIG | Peripheral output data, one bit per signal |
| periph_oe | input | N_SIG | Peripheral output enable, one bit per signal |
| periph_in | output | N_SIG | Resolved input to each peripheral signal |
| pad_out | output | N_PADS | Data driven to each pad |
| pad_oe | output | N_PADS | Output enable for each pad |
| pad_in | input | N_PADS | Data sampled from each pad |

## Verification
The bench sweeps every combination of select values across the four muxed pads. For each combination it applies complementary data patterns and checks every pad and every peripheral input. This catches three kinds of error: a wrong function-to-signal mapping, a priority that lets a later pad override an earlier one, and an unselected input left floating instead of idling at its default. The out-of-range select values on the three-function pad are part of the sweep. A design that decoded them as a real function would drive that pad when it should be disabled. Register checks cover bit truncation on narrow pads, writes with the relevant strobe clear, and unmapped or misaligned addresses. A decoder that wrapped such addresses onto a real pad would corrupt a select register or return nonzero data.

// File: rtl/padmux_pkg.sv
package padmux_pkg;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // number of functions offered by muxed pad 'pad'
  function automatic int unsigned pad_func_count(int unsigned pad, int unsigned max_func);
    return 2 + (pad % (max_func - 1));
  endfunction

  // stored select width for a pad with 'nfunc' functions
  function automatic int unsigned pad_sel_width(int unsigned nfunc);
    return (nfunc <= 2) ? 1 : $clog2(nfunc);
  endfunction

  // peripheral signal reached by function 'func' of pad 'pad'
  function automatic int unsigned pad_func_signal(int unsigned pad, int unsigned func,
                                                  int unsigned n_sig);
    return (pad + 3 * func) % n_sig;
  endfunction

endpackage

// File: rtl/padmux_regs.sv
module padmux_regs
  import padmux_pkg::*;
#(
  parameter int N_MUX      = 4,
  parameter int MAX_FUNC   = 4,
  parameter int SEL_W      = 2,
  parameter int ADDR_W     = 8,
  parameter int REG_STRIDE = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           s_awaddr,
  input  logic                        s_awvalid,
  output logic                        s_awready,
  input  logic [31:0]                 s_wdata,
  input  logic [3:0]                  s_wstrb,
  input  logic                        s_wvalid,
  output logic                        s_wready,
  output logic [1:0]                  s_bresp,
  output logic                        s_bvalid,
  input  logic                        s_bready,
  input  logic [ADDR_W-1:0]           s_araddr,
  input  logic                        s_arvalid,
  output logic                        s_arready,
  output logic [31:0]                 s_rdata,
  output logic [1:0]                  s_rresp,
  output logic                        s_rvalid,
  input  logic                        s_rready,
  output logic [N_MUX-1:0][SEL_W-1:0] sel
);

  logic              wr_go, rd_go, wr_map, rd_map, wr_lane_en;
  logic [ADDR_W-1:0] wr_idx, rd_idx;
  logic [1:0]        wr_lane, rd_lane;
  logic [7:0]        wr_byte;
  logic [SEL_W-1:0]  rd_val;

  assign wr_go     = s_awvalid && s_wvalid && !s_bvalid;
  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign rd_go     = s_arvalid && !s_rvalid;
  assign s_arready = rd_go;

  assign wr_idx     = s_awaddr / ADDR_W'(REG_STRIDE);
  assign rd_idx     = s_araddr / ADDR_W'(REG_STRIDE);
  assign wr_map     = ((s_awaddr % ADDR_W'(REG_STRIDE)) == '0) && (wr_idx < ADDR_W'(N_MUX));
  assign rd_map     = ((s_araddr % ADDR_W'(REG_STRIDE)) == '0) && (rd_idx < ADDR_W'(N_MUX));
  assign wr_lane    = s_awaddr[1:0];
  assign rd_lane    = s_araddr[1:0];
  assign wr_byte    = s_wdata[8*wr_lane +: 8];
  assign wr_lane_en = s_wstrb[wr_lane];

  for (genvar p = 0; p < N_MUX; p++) begin : g_reg
    localparam int PW = pad_sel_width(pad_func_count(p, MAX_FUNC));
    logic [SEL_W-1:0] sel_q;
    always_ff @(posedge clk) begin
      if (rst) sel_q <= '0;
      else if (wr_go && wr_map && wr_lane_en && (wr_idx == ADDR_W'(p)))
        sel_q <= SEL_W'(wr_byte[PW-1:0]);
    end
    assign sel[p] = sel_q;
  end

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < N_MUX; p++)
      if (rd_idx == ADDR_W'(p)) rd_val = sel[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_bvalid <= 1'b0;
      s_bresp  <= RESP_OKAY;
    end else if (wr_go) begin
      s_bvalid <= 1'b1;
      s_bresp  <= wr_map ? RESP_OKAY : RESP_SLVERR;
    end else if (s_bready) begin
      s_bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_rvalid <= 1'b0;
      s_rresp  <= RESP_OKAY;
      s_rdata  <= '0;
    end else if (rd_go) begin
      s_rvalid <= 1'b1;
      s_rresp  <= rd_map ? RESP_OKAY : RESP_SLVERR;
      s_rdata  <= rd_map ? (32'(rd_val) << (8 * rd_lane)) : 32'd0;
    end else if (s_rready) begin
      s_rvalid <= 1'b0;
    end
  end

  AST_WR_GETS_RESP: assert property (@(posedge clk) disable iff (rst)
    (s_awvalid && s_awready) |=> s_bvalid); // R10
  AST_RESP_HELD: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp))); // R10
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && s_rresp == RESP_SLVERR) |-> (s_rdata == 32'd0)); // R9
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_go && !wr_map) |=> $stable(sel)); // R9

endmodule

// File: rtl/padmux_pad_steer.sv
module padmux_pad_steer
  import padmux_pkg::*;
#(
  parameter int PAD       = 0,
  parameter int MAX_FUNC  = 4,
  parameter int SEL_W     = 2,
  parameter int N_MUX_SIG = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     sel,
  input  logic [N_MUX_SIG-1:0] periph_out,
  input  logic [N_MUX_SIG-1:0] periph_oe,
  output logic                 pad_out,
  output logic                 pad_oe
);

  localparam int FC = pad_func_count(PAD, MAX_FUNC);

  logic nxt_out, nxt_oe;

  always_comb begin
    nxt_out = 1'b0;
    nxt_oe  = 1'b0;
    for (int f = 0; f < FC; f++) begin
      if (sel == SEL_W'(f)) begin
        nxt_out = periph_out[pad_func_signal(PAD, f, N_MUX_SIG)];
        nxt_oe  = periph_oe[pad_func_signal(PAD, f, N_MUX_SIG)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end

  AST_BAD_SEL_OFF: assert property (@(posedge clk) disable iff (rst)
    (int'(sel) >= FC) |=> (!pad_oe && !pad_out)); // R4

endmodule

// File: rtl/padmux_in_select.sv
module padmux_in_select
  import padmux_pkg::*;
#(
  parameter int N_MUX     = 4,
  parameter int N_MUX_SIG = 8,
  parameter int MAX_FUNC  = 4,
  parameter int SEL_W     = 2,
  parameter logic [N_MUX_SIG-1:0] IN_DEFAULT = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_MUX-1:0][SEL_W-1:0] sel,
  input  logic [N_MUX-1:0]            pad_in,
  output logic [N_MUX_SIG-1:0]        periph_in
);

  localparam int SIGW = (N_MUX_SIG > 1) ? $clog2(N_MUX_SIG) : 1;

  logic [N_MUX_SIG-1:0] nxt_in;
  logic [SIGW-1:0]      first_sig;

  // walk pads from last to first so the lowest index is applied last
  always_comb begin
    nxt_in = IN_DEFAULT;
    for (int s = 0; s < N_MUX_SIG; s++) begin
      for (int p = N_MUX - 1; p >= 0; p--) begin
        for (int f = 0; f < int'(pad_func_count(p, MAX_FUNC)); f++) begin
          if (sel[p] == SEL_W'(f) && pad_func_signal(p, f, N_MUX_SIG) == s)
            nxt_in[s] = pad_in[p];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) periph_in <= IN_DEFAULT;
    else     periph_in <= nxt_in;
  end

  always_comb first_sig = SIGW'(pad_func_signal(0, int'(sel[0]), N_MUX_SIG));

  AST_FIRST_PAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (int'(sel[0]) < int'(pad_func_count(0, MAX_FUNC)))
      |=> (periph_in[$past(first_sig)] == $past(pad_in[0]))); // R6

endmodule

// File: rtl/padmux_ctrl.sv
module padmux_ctrl
  import padmux_pkg::*;
#(
  parameter int N_MUX_PADS = 4,
  parameter int N_DED_PADS = 2,
  parameter int N_MUX_SIG  = 8,
  parameter int MAX_FUNC   = 4,
  parameter int ADDR_W     = 8,
  parameter int REG_STRIDE = 4,
  parameter logic [N_MUX_SIG+N_DED_PADS-1:0] IN_DEFAULT = 10'b00_0000_1001
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [ADDR_W-1:0]                s_awaddr,
  input  logic                             s_awvalid,
  output logic                             s_awready,
  input  logic [31:0]                      s_wdata,
  input  logic [3:0]                       s_wstrb,
  input  logic                             s_wvalid,
  output logic                             s_wready,
  output logic [1:0]                       s_bresp,
  output logic                             s_bvalid,
  input  logic                             s_bready,
  input  logic [ADDR_W-1:0]                s_araddr,
  input  logic                             s_arvalid,
  output logic                             s_arready,
  output logic [31:0]                      s_rdata,
  output logic [1:0]                       s_rresp,
  output logic                             s_rvalid,
  input  logic                             s_rready,
  input  logic [N_MUX_SIG+N_DED_PADS-1:0]  periph_out,
  input  logic [N_MUX_SIG+N_DED_PADS-1:0]  periph_oe,
  output logic [N_MUX_SIG+N_DED_PADS-1:0]  periph_in,
  output logic [N_MUX_PADS+N_DED_PADS-1:0] pad_out,
  output logic [N_MUX_PADS+N_DED_PADS-1:0] pad_oe,
  input  logic [N_MUX_PADS+N_DED_PADS-1:0] pad_in
);

  localparam int N_PADS = N_MUX_PADS + N_DED_PADS;
  localparam int N_SIG  = N_MUX_SIG + N_DED_PADS;
  localparam int SEL_W  = (MAX_FUNC > 2) ? $clog2(MAX_FUNC) : 1;

  logic [N_MUX_PADS-1:0][SEL_W-1:0] sel;

  padmux_regs #(
    .N_MUX(N_MUX_PADS), .MAX_FUNC(MAX_FUNC), .SEL_W(SEL_W),
    .ADDR_W(ADDR_W), .REG_STRIDE(REG_STRIDE)
  ) i_regs (
    .clk, .rst,
    .s_awaddr, .s_awvalid, .s_awready, .s_wdata, .s_wstrb, .s_wvalid, .s_wready,
    .s_bresp, .s_bvalid, .s_bready,
    .s_araddr, .s_arvalid, .s_arready, .s_rdata, .s_rresp, .s_rvalid, .s_rready,
    .sel
  );

  for (genvar p = 0; p < N_MUX_PADS; p++) begin : g_mux_pad
    padmux_pad_steer #(
      .PAD(p), .MAX_FUNC(MAX_FUNC), .SEL_W(SEL_W), .N_MUX_SIG(N_MUX_SIG)
    ) i_steer (
      .clk, .rst,
      .sel       (sel[p]),
      .periph_out(periph_out[N_MUX_SIG-1:0]),
      .periph_oe (periph_oe[N_MUX_SIG-1:0]),
      .pad_out   (pad_out[p]),
      .pad_oe    (pad_oe[p])
    );
  end

  padmux_in_select #(
    .N_MUX(N_MUX_PADS), .N_MUX_SIG(N_MUX_SIG), .MAX_FUNC(MAX_FUNC), .SEL_W(SEL_W),
    .IN_DEFAULT(IN_DEFAULT[N_MUX_SIG-1:0])
  ) i_in_sel (
    .clk, .rst, .sel,
    .pad_in   (pad_in[N_MUX_PADS-1:0]),
    .periph_in(periph_in[N_MUX_SIG-1:0])
  );

  for (genvar d = 0; d < N_DED_PADS; d++) begin : g_ded_pad
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[N_MUX_PADS+d]  <= 1'b0;
        pad_oe[N_MUX_PADS+d]   <= 1'b0;
        periph_in[N_MUX_SIG+d] <= IN_DEFAULT[N_MUX_SIG+d];
      end else begin
        pad_out[N_MUX_PADS+d]  <= periph_out[N_MUX_SIG+d];
        pad_oe[N_MUX_PADS+d]   <= periph_oe[N_MUX_SIG+d];
        periph_in[N_MUX_SIG+d] <= pad_in[N_MUX_PADS+d];
      end
    end

    AST_DED_PASS: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (pad_oe[N_MUX_PADS+d] == $past(periph_oe[N_MUX_SIG+d]) &&
                periph_in[N_MUX_SIG+d] == $past(pad_in[N_MUX_PADS+d]))); // R5
  end

  initial begin
    if (N_PADS < 1 || N_SIG < 1 || MAX_FUNC < 2 || REG_STRIDE < 1)
      $error("padmux_ctrl: illegal parameter set");
  end

endmodule

// File: tb/test_padmux_ctrl.sv
`timescale 1ns/1ps
module test_padmux_ctrl;

  localparam int NM = 4, ND = 2, NMS = 8, NP = NM + ND, NS = NMS + ND;
  localparam logic [NS-1:0] DEF = 10'b00_0000_1001;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 0, s_wvalid = 0, s_arvalid = 0, s_bready = 1, s_rready = 1;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [NS-1:0] periph_out = '0, periph_oe = '0, periph_in;
  logic [NP-1:0] pad_out, pad_oe, pad_in = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  padmux_ctrl i_padmux_ctrl (.*);

  function automatic int fcount(int p); return 2 + p % 3; endfunction
  function automatic int sigof(int p, int f); return (p + 3 * f) % NMS; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic axi_write(logic [7:0] a, logic [31:0] d, logic [3:0] st, output logic [1:0] resp);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = st; s_awvalid = 1; s_wvalid = 1;
    #1;
    while (!s_awready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    resp = s_bresp;
    chk("R10 bvalid", s_bvalid, 1);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
  endtask

  task automatic axi_read(logic [7:0] a, output logic [31:0] d, output logic [1:0] resp);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    d = s_rdata; resp = s_rresp;
    @(negedge clk);
    s_arvalid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0]  r;
    logic [31:0] d;
    int sel_m [NM];
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state of every select register
    for (int p = 0; p < NM; p++) begin
      axi_read(8'(p * 4), d, r);
      chk("R1 reset select", d, 0);
      chk("R9 okay on mapped read", r, 2'b00);
    end

    // R2: narrow fields drop high bits
    axi_write(8'h00, 32'hFF, 4'h1, r);
    chk("R10 okay response", r, 2'b00);
    axi_read(8'h00, d, r); chk("R2 pad0 truncated", d, 1);
    axi_write(8'h04, 32'hFE, 4'h1, r);
    axi_read(8'h04, d, r); chk("R2 pad1 truncated", d, 2);
    // R8: cleared strobe on the value lane blocks the write
    axi_write(8'h04, 32'hFFFF_FF01, 4'hE, r);
    axi_read(8'h04, d, r); chk("R8 strobe clear keeps value", d, 2);
    axi_write(8'h08, 32'h3, 4'h1, r);
    axi_read(8'h08, d, r); chk("R8 strobe set writes", d, 3);
    // R9: unmapped and misaligned
    axi_write(8'h10, 32'h1, 4'hF, r); chk("R9 unmapped write resp", r, 2'b10);
    axi_write(8'h06, 32'h1, 4'hF, r); chk("R9 misaligned write resp", r, 2'b10);
    axi_read(8'h04, d, r); chk("R9 no side write", d, 2);
    axi_read(8'h08, d, r); chk("R9 no side write pad2", d, 3);
    axi_read(8'h10, d, r);
    chk("R9 unmapped read resp", r, 2'b10); chk("R9 unmapped read data", d, 0);
    axi_read(8'h05, d, r);
    chk("R9 misaligned read resp", r, 2'b10); chk("R9 misaligned read data", d, 0);

    // exhaustive sweep of all select combinations
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int e = 0; e < 2; e++) begin
            sel_m[0] = a; sel_m[1] = b; sel_m[2] = c; sel_m[3] = e;
            for (int p = 0; p < NM; p++) axi_write(8'(p * 4), 32'(sel_m[p]), 4'h1, r);
            for (int k = 0; k < 2; k++) begin
              logic [NS-1:0] po, poe;
              logic [NP-1:0] pin;
              po = NS'($urandom); poe = NS'($urandom); pin = NP'($urandom);
              if (k == 1) begin po = ~po; poe = ~poe; pin = ~pin; end
              @(negedge clk);
              periph_out = po; periph_oe = poe; pad_in = pin;
              @(negedge clk);
              for (int p = 0; p < NM; p++) begin
                if (sel_m[p] < fcount(p)) begin
                  chk("R3 pad out", pad_out[p], po[sigof(p, sel_m[p])]);
                  chk("R3 pad oe", pad_oe[p], poe[sigof(p, sel_m[p])]);
                end else begin
                  chk("R4 disabled out", pad_out[p], 0);
                  chk("R4 disabled oe", pad_oe[p], 0);
                end
              end
              for (int dd = 0; dd < ND; dd++) begin
                chk("R5 dedicated out", pad_out[NM+dd], po[NMS+dd]);
                chk("R5 dedicated oe", pad_oe[NM+dd], poe[NMS+dd]);
                chk("R5 dedicated in", periph_in[NMS+dd], pin[NM+dd]);
              end
              for (int s = 0; s < NMS; s++) begin
                logic expv; bit hit;
                expv = DEF[s]; hit = 0;
                for (int p = NM - 1; p >= 0; p--)
                  if (sel_m[p] < fcount(p) && sigof(p, sel_m[p]) == s) begin
                    expv = pin[p]; hit = 1;
                  end
                if (hit) chk("R6 priority input", periph_in[s], expv);
                else     chk("R7 idle default", periph_in[s], expv);
              end
            end
          end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule